// File: doc/BRIEF.md
# Multi-Core Run/Stop Controller

This block starts and halts a group of processor cores and keeps a bitmask of the cores that are running. Software reaches it through a small register interface: a write to the run register asks the selected cores to start, a write to the stop register asks the selected cores to halt, and a read of the status register returns the running mask. For each core the block drives a one-cycle start pulse and a one-cycle halt pulse. A core that receives a start pulse resets itself, leaves halt, and then answers with a start acknowledge. The block records the core as running only when that acknowledge arrives.

Each of the three registers appears twice: once in a local window at byte offset 0x0000 and once in a second window at 0x2000. Both copies behave the same. After reset the running mask is empty, and on the first clock after reset is released the block launches the cores that the `START_RUNNING` parameter selects. The parameter `NUM_VP` sets the core count. A `START_RUNNING` value with a bit at or above `NUM_VP` stops elaboration with an error.

Top module: `vp_run_ctrl`

## Requirements
- R1: Write data bits at positions `NUM_VP` and above are discarded for run and stop commands.
- R2: A run write produces a start pulse exactly one cycle long, in the cycle after the write. The pulse goes only to selected cores that are neither running nor waiting for an acknowledge. Running cores see no pulse.
- R3: A core's running bit is set at the clock edge where its start acknowledge is high, and only if that core has a start outstanding. An acknowledge with no start outstanding is ignored.
- R4: A stop write produces a one-cycle halt pulse, in the cycle after the write, only for selected cores that are running. It clears their running bits. Stopping a core that is not running produces no halt.
- R5: If a stop command and a start acknowledge for the same core arrive in the same cycle, the stop wins. The core receives a halt pulse and its running bit stays clear.
- R6: The run, stop and status registers sit at byte offsets 0x00, 0x08 and 0x10 within a window. Address bit 13 selects the local window (0) or the second window (1), and both windows behave identically.
- R7: During reset, no start or halt pulse is driven, read-valid is low and the running mask is zero. On the first cycle after release, start pulses go to the cores set in `START_RUNNING`.
- R8: `rd_valid` rises one cycle after `rd_en`. `rd_data` then carries the running mask as it was in the request cycle, zero-extended to 64 bits. A read of any other offset returns zero, and a write to any other offset has no effect.
- R9: Byte enable bit i gates write data bits 8i+7 down to 8i. A disabled byte reads as zero to the command.
- R10: A core that has a start outstanding gets no second start pulse from a further run write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wr_data | input | 64 | Write data |
| wr_be | input | 8 | Write byte enables |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 64 | Read data |
| core_start | output | NUM_VP | One-cycle start pulse per core |
| core_halt | output | NUM_VP | One-cycle halt pulse per core |
| start_ack | input | NUM_VP | Per-core start-complete acknowledge |

## Verification
The bench builds the block with `NUM_VP` = 4 and `START_RUNNING` = 5. This makes the reset launch a non-trivial pattern with gaps in it. It also leaves room for an all-ones write whose upper bits must be discarded. With four cores, one stimulus can mix running, stopped and start-outstanding cores, so a single run or stop write checks the per-core filtering. The same set of cores is used for the stray acknowledge, the repeated run during a start, and the collision between a stop and an acknowledge.

// File: rtl/vprc_pkg.sv
package vprc_pkg;
    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_RUN,
        SEL_STOP,
        SEL_STAT
    } reg_sel_e;

    localparam int WIN_SEL_BIT = 13;
    localparam logic [12:0] OFF_RUN  = 13'h000;
    localparam logic [12:0] OFF_STOP = 13'h008;
    localparam logic [12:0] OFF_STAT = 13'h010;

    typedef struct packed {
        logic start;
        logic halt;
        logic pending;
        logic running;
    } slice_state_t;

    typedef struct packed {
        logic        boot;
        logic        rvalid;
        logic [63:0] rdata;
    } top_state_t;
endpackage

// File: rtl/vprc_decode.sv
module vprc_decode
    import vprc_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int OFF_W = WIN_SEL_BIT;

    logic [OFF_W-1:0] offset;
    logic             upper_zero;

    assign offset = addr[OFF_W-1:0];

    generate
        if (ADDR_W > WIN_SEL_BIT + 1) begin : g_upper
            assign upper_zero = (addr[ADDR_W-1:WIN_SEL_BIT+1] == '0);
        end else begin : g_no_upper
            assign upper_zero = 1'b1;
        end
    endgenerate

    always_comb begin
        sel = SEL_NONE;
        if (upper_zero) begin
            case (offset)
                OFF_RUN:  sel = SEL_RUN;
                OFF_STOP: sel = SEL_STOP;
                OFF_STAT: sel = SEL_STAT;
                default:  sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/vprc_slice.sv
module vprc_slice
    import vprc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic boot_i,
    input  logic run_i,
    input  logic stop_i,
    input  logic ack_i,
    output logic start_o,
    output logic halt_o,
    output logic running_o
);
    slice_state_t st_d, st_q;
    logic ack_ok;
    logic live;
    logic launch;

    always_comb begin
        st_d   = st_q;
        ack_ok = ack_i & st_q.pending;
        live   = st_q.running | ack_ok;
        launch = (run_i | boot_i) & ~st_q.running & ~st_q.pending;
        st_d.start   = launch;
        st_d.halt    = stop_i & live;
        st_d.running = live & ~stop_i;
        st_d.pending = (st_q.pending & ~ack_ok) | launch;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o   = st_q.start;
    assign halt_o    = st_q.halt;
    assign running_o = st_q.running;

    p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.start |=> !st_q.start);
    p_start_idle_core_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.start |-> (st_q.pending && !st_q.running));
    p_run_by_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.running) |-> $past(ack_i));
    p_halt_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.halt |-> !st_q.running);
    p_stop_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !st_q.running);
endmodule

// File: rtl/vp_run_ctrl.sv
module vp_run_ctrl
    import vprc_pkg::*;
#(
    parameter int          NUM_VP        = 1,
    parameter logic [63:0] START_RUNNING = 64'h1,
    parameter int          ADDR_W        = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [63:0]       wr_data,
    input  logic [7:0]        wr_be,
    output logic              rd_valid,
    output logic [63:0]       rd_data,
    output logic [NUM_VP-1:0] core_start,
    output logic [NUM_VP-1:0] core_halt,
    input  logic [NUM_VP-1:0] start_ack
);
    localparam int          BYTES   = 8;
    localparam logic [63:0] VP_MASK = {64{1'b1}} >> (64 - NUM_VP);

    generate
        if (NUM_VP < 1 || NUM_VP > 64) begin : g_bad_count
            $error("vp_run_ctrl: NUM_VP must lie in 1..64");
        end
        if ((START_RUNNING & ~VP_MASK) != 64'h0) begin : g_bad_start
            $error("vp_run_ctrl: START_RUNNING selects cores beyond NUM_VP");
        end
    endgenerate

    reg_sel_e          sel;
    logic [63:0]       data_m;
    logic [NUM_VP-1:0] run_vec;
    logic [NUM_VP-1:0] stop_vec;
    logic [NUM_VP-1:0] running;
    top_state_t        tp_d, tp_q;

    vprc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (addr),
        .sel  (sel)
    );

    for (genvar b = 0; b < BYTES; b++) begin : g_be
        assign data_m[8*b +: 8] = wr_be[b] ? wr_data[8*b +: 8] : 8'h00;
    end

    always_comb begin
        run_vec  = '0;
        stop_vec = '0;
        if (wr_en && sel == SEL_RUN)  run_vec  = data_m[NUM_VP-1:0];
        if (wr_en && sel == SEL_STOP) stop_vec = data_m[NUM_VP-1:0];
    end

    for (genvar c = 0; c < NUM_VP; c++) begin : g_core
        vprc_slice u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .boot_i    (tp_q.boot & START_RUNNING[c]),
            .run_i     (run_vec[c]),
            .stop_i    (stop_vec[c]),
            .ack_i     (start_ack[c]),
            .start_o   (core_start[c]),
            .halt_o    (core_halt[c]),
            .running_o (running[c])
        );
    end

    always_comb begin
        tp_d        = tp_q;
        tp_d.boot   = 1'b0;
        tp_d.rvalid = rd_en;
        if (rd_en) begin
            tp_d.rdata = (sel == SEL_STAT) ? 64'(running) : 64'h0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tp_q.boot   <= 1'b1;
            tp_q.rvalid <= 1'b0;
            tp_q.rdata  <= '0;
        end else begin
            tp_q <= tp_d;
        end
    end

    assign rd_valid = tp_q.rvalid;
    assign rd_data  = tp_q.rdata;

    p_read_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    p_read_other_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel != SEL_STAT) |=> (rd_data == 64'h0));
    p_boot_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tp_q.boot |=> !tp_q.boot);
endmodule

// File: tb/vp_run_ctrl_tb.sv
module vp_run_ctrl_tb;
    localparam int N  = 4;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [63:0]   wr_data = '0;
    logic [7:0]    wr_be = '0;
    logic          rd_valid;
    logic [63:0]   rd_data;
    logic [N-1:0]  core_start;
    logic [N-1:0]  core_halt;
    logic [N-1:0]  start_ack = '0;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    vp_run_ctrl #(.NUM_VP(N), .START_RUNNING(64'h5), .ADDR_W(AW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .wr_be      (wr_be),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .core_start (core_start),
        .core_halt  (core_halt),
        .start_ack  (start_ack)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, let a posedge sample, return at next negedge
    task automatic tick(input bit wr, input bit rd, input logic [AW-1:0] a,
                        input logic [63:0] d, input logic [7:0] be,
                        input logic [N-1:0] ack);
        wr_en = wr; rd_en = rd; addr = a; wr_data = d; wr_be = be; start_ack = ack;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; start_ack = '0;
    endtask

    task automatic rd_stat(input logic [AW-1:0] a, input logic [63:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        tick(0, 1, a, '0, '0, '0);
    endtask

    task automatic pulses(input logic [N-1:0] s, input logic [N-1:0] h, input string tag);
        check(core_start == s, {tag, " start"}, 64'(core_start), 64'(s));
        check(core_halt == h, {tag, " halt"}, 64'(core_halt), 64'(h));
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rd_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8 unexpected rd_valid", 64'(rd_valid), 64'h0);
                end else begin
                    automatic logic [63:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(rd_data == e, t, rd_data, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R7: quiet outputs while reset is held
        pulses('0, '0, "R7 during reset");
        check(rd_valid == 1'b0, "R7 rd_valid in reset", 64'(rd_valid), 64'h0);
        rst_n = 1'b1;
        tick(0, 0, '0, '0, '0, '0);
        pulses(4'b0101, '0, "R7 reset launch");
        rd_stat(14'h0010, 64'h0, "R3 not running before ack");
        pulses('0, '0, "R2 start lasts one cycle");
        tick(0, 0, '0, '0, '0, 4'b0101);
        rd_stat(14'h0010, 64'h5, "R3 running after ack");

        // R1 + R2: all-ones write, only idle cores 1 and 3 start
        tick(1, 0, 14'h0000, {64{1'b1}}, 8'hFF, '0);
        pulses(4'b1010, '0, "R1 R2 masked run");
        rd_stat(14'h2010, 64'h5, "R6 second window status while pending");
        // R10: pending core 1 is not pulsed again
        tick(1, 0, 14'h0000, 64'h2, 8'hFF, '0);
        pulses('0, '0, "R10 no relaunch while pending");
        tick(0, 0, '0, '0, '0, 4'b1111);
        rd_stat(14'h0010, 64'hF, "R3 all running");

        // R4 through the second window
        tick(1, 0, 14'h2008, 64'h3, 8'hFF, '0);
        pulses('0, 4'b0011, "R4 R6 stop running cores");
        rd_stat(14'h0010, 64'hC, "R4 bits cleared");
        tick(1, 0, 14'h0008, 64'h3, 8'hFF, '0);
        pulses('0, '0, "R4 stop of stopped cores");
        tick(1, 0, 14'h0000, 64'h4, 8'hFF, '0);
        pulses('0, '0, "R2 running core not restarted");

        // R3 stray acknowledge
        tick(0, 0, '0, '0, '0, 4'b0001);
        rd_stat(14'h0010, 64'hC, "R3 stray ack ignored");

        // R8 unimplemented offset
        tick(1, 0, 14'h0018, 64'hF, 8'hFF, '0);
        pulses('0, '0, "R8 write to hole");
        rd_stat(14'h0018, 64'h0, "R8 read of hole");
        rd_stat(14'h2010, 64'hC, "R8 state unchanged after hole write");

        // R9 byte enables
        tick(1, 0, 14'h2000, 64'h1, 8'h00, '0);
        pulses('0, '0, "R9 all bytes disabled");
        tick(1, 0, 14'h2000, 64'h2, 8'hFE, '0);
        pulses('0, '0, "R9 byte0 disabled");
        tick(1, 0, 14'h2000, 64'h1, 8'h01, '0);
        pulses(4'b0001, '0, "R9 R6 byte0 enabled run");

        // R5 stop and ack together on core 0
        tick(1, 0, 14'h0008, 64'h1, 8'hFF, 4'b0001);
        pulses('0, 4'b0001, "R5 stop beats ack");
        rd_stat(14'h0010, 64'hC, "R5 running stays clear");

        // stop of a pending core leaves its start outstanding
        tick(1, 0, 14'h0000, 64'h2, 8'hFF, '0);
        pulses(4'b0010, '0, "R2 relaunch stopped core");
        tick(1, 0, 14'h0008, 64'h2, 8'hFF, '0);
        pulses('0, '0, "R4 no halt for pending core");
        tick(0, 0, '0, '0, '0, 4'b0010);
        rd_stat(14'h0010, 64'hE, "R3 ack after stop");
        tick(0, 0, '0, '0, '0, '0);

        check(exp_q.size() == 0, "R8 reads answered", 64'(exp_q.size()), 64'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule